// File: doc/BRIEF.md
# Pipeline Data-Hazard Resolver

This block decides, cycle by cycle, how a five-stage in-order pipeline (fetch, decode with register read, execute, memory, writeback) avoids reading stale operands. For the instruction now in execute it picks, for each ALU operand, where the value comes from. The choices are the value read from the register file during decode, the result held in the memory stage, or the result held in the writeback stage. When the producer one stage ahead is a load, its value does not exist yet when the consumer needs it. In that case the block raises a stall for one cycle, and it asks for a bubble to be placed in the execute stage.

The register file lives inside the block. A write from writeback appears on the decode read ports in the same cycle. An instruction three positions behind its producer therefore needs no forwarding path. The stall output freezes the program counter and the fetch/decode register. The bubble output clears the control bits entering execute, so the stalled slot behaves like a no-op all the way to writeback.

Top module: `hazard_unit`

## Requirements
- R1: When the memory-stage producer writes a nonzero register equal to an execute-stage source, that operand's select is 2 (memory-stage result).
- R2: When only the writeback-stage producer matches a nonzero execute-stage source, that operand's select is 1 (writeback result). With no match the select is 0 (register-file value).
- R3: When both the memory-stage and the writeback-stage producers match the same source, the select is 2, because the youngest producer wins.
- R4: Register 0 never causes forwarding and never causes a stall.
- R5: A producer whose write enable is low is ignored by both forwarding and stall detection.
- R6: When the execute-stage instruction is a writing load whose nonzero destination equals either decode source, stall and bubble are both 1 in that cycle.
- R7: No stall occurs when the execute-stage load is independent of the decode sources, or when the matching execute-stage producer is not a load.
- R8: A register-file write from writeback is visible on a decode read port in the same cycle it is presented.
- R9: After reset every register reads 0, and register 0 reads 0 even after a write to it.
- R10: A written value stays readable in later cycles without further writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears the register file |
| idRs1 | input | ADDR_W | First source register of the decode instruction |
| idRs2 | input | ADDR_W | Second source register of the decode instruction |
| exRs1 | input | ADDR_W | First source register of the execute instruction |
| exRs2 | input | ADDR_W | Second source register of the execute instruction |
| exRd | input | ADDR_W | Destination register of the execute instruction |
| exRegWrite | input | 1 | Execute instruction writes a register |
| exIsLoad | input | 1 | Execute instruction is a load |
| memRd | input | ADDR_W | Destination register of the memory-stage instruction |
| memRegWrite | input | 1 | Memory-stage instruction writes a register |
| wbRd | input | ADDR_W | Destination register of the writeback instruction |
| wbRegWrite | input | 1 | Writeback instruction writes a register |
| wbData | input | DATA_W | Value being written back |
| rdData1 | output | DATA_W | Decode read of idRs1, writeback bypass applied |
| rdData2 | output | DATA_W | Decode read of idRs2, writeback bypass applied |
| fwdSelA | output | 2 | Operand A source: 0 register file, 1 writeback, 2 memory stage |
| fwdSelB | output | 2 | Operand B source, same encoding |
| stall | output | 1 | Hold program counter and fetch/decode register |
| bubble | output | 1 | Clear control bits entering execute |

## Verification
Two functions can act in the same cycle. A load in execute can collide with the decode instruction while the execute instruction itself forwards from the memory and writeback stages. The stimulus table holds a vector built that way. It is judged by requiring stall high together with both operand selects taking their separate forwarding values. A second overlap comes from the register file. A writeback write and a decode read of the same register are applied in one cycle, and the read port must show the new value before the clock edge.

// File: rtl/hazard_pkg.sv
package hazard_pkg;

  typedef enum logic [1:0] {
    FWD_RF  = 2'd0,
    FWD_WB  = 2'd1,
    FWD_MEM = 2'd2
  } fwd_sel_e;

  // strobes from hazard control toward the pipeline datapath
  typedef struct packed {
    logic     stall;
    logic     bubble;
    fwd_sel_e fwdA;
    fwd_sel_e fwdB;
  } hz_ctl_t;

endpackage

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
  import hazard_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] idRs1,
  input  logic [ADDR_W-1:0] idRs2,
  input  logic [ADDR_W-1:0] exRs1,
  input  logic [ADDR_W-1:0] exRs2,
  input  logic [ADDR_W-1:0] exRd,
  input  logic              exRegWrite,
  input  logic              exIsLoad,
  input  logic [ADDR_W-1:0] memRd,
  input  logic              memRegWrite,
  input  logic [ADDR_W-1:0] wbRd,
  input  logic              wbRegWrite,
  output hz_ctl_t           ctl
);

  localparam logic [ADDR_W-1:0] ZERO_REG = '0;

  logic memLive, wbLive, loadLive, loadHit;

  assign memLive  = memRegWrite && (memRd != ZERO_REG);
  assign wbLive   = wbRegWrite && (wbRd != ZERO_REG);
  assign loadLive = exIsLoad && exRegWrite && (exRd != ZERO_REG);
  assign loadHit  = loadLive && ((exRd == idRs1) || (exRd == idRs2));

  // youngest producer is checked first
  function automatic fwd_sel_e pickSrc(input logic [ADDR_W-1:0] src);
    if (memLive && (memRd == src))
      return FWD_MEM;
    else if (wbLive && (wbRd == src))
      return FWD_WB;
    else
      return FWD_RF;
  endfunction

  always_comb begin
    ctl.fwdA   = pickSrc(exRs1);
    ctl.fwdB   = pickSrc(exRs2);
    ctl.stall  = loadHit;
    ctl.bubble = loadHit;
  end

endmodule

// File: rtl/hazard_regfile.sv
module hazard_regfile #(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = $clog2(NUM_REGS),
  parameter int RD_PORTS = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [RD_PORTS-1:0][ADDR_W-1:0] rdAddr,
  output logic [RD_PORTS-1:0][DATA_W-1:0] rdData,
  input  logic                           wrEn,
  input  logic [ADDR_W-1:0]              wrAddr,
  input  logic [DATA_W-1:0]              wrData
);

  localparam logic [ADDR_W-1:0] ZERO_REG = '0;

  logic [DATA_W-1:0] regs [NUM_REGS];
  logic              wrLive;

  assign wrLive = wrEn && (wrAddr != ZERO_REG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
    end else if (wrLive) begin
      regs[wrAddr] <= wrData;
    end
  end

  // write-before-read: the writeback value reaches decode in the same cycle
  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
    always_comb begin
      if (rdAddr[p] == ZERO_REG)
        rdData[p] = '0;
      else if (wrLive && (wrAddr == rdAddr[p]))
        rdData[p] = wrData;
      else
        rdData[p] = regs[rdAddr[p]];
    end
  end

endmodule

// File: rtl/hazard_unit.sv
module hazard_unit
  import hazard_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] idRs1,
  input  logic [ADDR_W-1:0] idRs2,
  input  logic [ADDR_W-1:0] exRs1,
  input  logic [ADDR_W-1:0] exRs2,
  input  logic [ADDR_W-1:0] exRd,
  input  logic              exRegWrite,
  input  logic              exIsLoad,
  input  logic [ADDR_W-1:0] memRd,
  input  logic              memRegWrite,
  input  logic [ADDR_W-1:0] wbRd,
  input  logic              wbRegWrite,
  input  logic [DATA_W-1:0] wbData,
  output logic [DATA_W-1:0] rdData1,
  output logic [DATA_W-1:0] rdData2,
  output logic [1:0]        fwdSelA,
  output logic [1:0]        fwdSelB,
  output logic              stall,
  output logic              bubble
);

  hz_ctl_t                  ctl;
  logic [1:0][ADDR_W-1:0]   rdAddr;
  logic [1:0][DATA_W-1:0]   rdData;

  hazard_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .idRs1(idRs1), .idRs2(idRs2),
    .exRs1(exRs1), .exRs2(exRs2),
    .exRd(exRd), .exRegWrite(exRegWrite), .exIsLoad(exIsLoad),
    .memRd(memRd), .memRegWrite(memRegWrite),
    .wbRd(wbRd), .wbRegWrite(wbRegWrite),
    .ctl(ctl)
  );

  assign rdAddr = {idRs2, idRs1};

  hazard_regfile #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .RD_PORTS(2)
  ) u_rf (
    .clk(clk), .rst_n(rst_n),
    .rdAddr(rdAddr), .rdData(rdData),
    .wrEn(wbRegWrite), .wrAddr(wbRd), .wrData(wbData)
  );

  assign rdData1 = rdData[0];
  assign rdData2 = rdData[1];
  assign fwdSelA = ctl.fwdA;
  assign fwdSelB = ctl.fwdB;
  assign stall   = ctl.stall;
  assign bubble  = ctl.bubble;

endmodule

// File: rtl/hazard_unit_checker.sv
module hazard_unit_checker #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] idRs1,
  input logic [ADDR_W-1:0] idRs2,
  input logic [ADDR_W-1:0] exRs1,
  input logic [ADDR_W-1:0] exRd,
  input logic              exRegWrite,
  input logic              exIsLoad,
  input logic [ADDR_W-1:0] memRd,
  input logic              memRegWrite,
  input logic [ADDR_W-1:0] wbRd,
  input logic              wbRegWrite,
  input logic [DATA_W-1:0] wbData,
  input logic [DATA_W-1:0] rdData1,
  input logic [1:0]        fwdSelA,
  input logic              stall,
  input logic              bubble
);

  logic pastValid;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pastValid <= 1'b0;
    else        pastValid <= 1'b1;

  AST_MEM_FWD_A: assert property (@(posedge clk) disable iff (!rst_n)
    (memRegWrite && memRd != '0 && memRd == exRs1) |-> fwdSelA == 2'd2); // R3

  AST_ZERO_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    (exRs1 == '0) |-> fwdSelA == 2'd0); // R4

  AST_LOAD_USE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (exIsLoad && exRegWrite && exRd != '0 && (exRd == idRs1 || exRd == idRs2))
      |-> (stall && bubble)); // R6

  AST_NONLOAD_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    !exIsLoad |-> !stall); // R7

  AST_WB_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (wbRegWrite && wbRd != '0 && wbRd == idRs1) |-> rdData1 == wbData); // R8

  AST_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (pastValid && $past(wbRegWrite && wbRd != '0 && wbRd == idRs1)
      && $stable(idRs1) && !wbRegWrite) |-> rdData1 == $past(wbData)); // R10

endmodule

bind hazard_unit hazard_unit_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .idRs1(idRs1), .idRs2(idRs2), .exRs1(exRs1),
  .exRd(exRd), .exRegWrite(exRegWrite), .exIsLoad(exIsLoad),
  .memRd(memRd), .memRegWrite(memRegWrite), .wbRd(wbRd),
  .wbRegWrite(wbRegWrite), .wbData(wbData), .rdData1(rdData1),
  .fwdSelA(fwdSelA), .stall(stall), .bubble(bubble)
);

// File: tb/test_hazard_unit.sv
module test_hazard_unit;

  localparam int AW = 5;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] idRs1 = '0, idRs2 = '0, exRs1 = '0, exRs2 = '0, exRd = '0;
  logic [AW-1:0] memRd = '0, wbRd = '0;
  logic          exRegWrite = 1'b0, exIsLoad = 1'b0, memRegWrite = 1'b0, wbRegWrite = 1'b0;
  logic [DW-1:0] wbData = '0;
  logic [DW-1:0] rdData1, rdData2;
  logic [1:0]    fwdSelA, fwdSelB;
  logic          stall, bubble;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  hazard_unit i_hazard_unit (
    .clk(clk), .rst_n(rst_n), .idRs1(idRs1), .idRs2(idRs2),
    .exRs1(exRs1), .exRs2(exRs2), .exRd(exRd), .exRegWrite(exRegWrite),
    .exIsLoad(exIsLoad), .memRd(memRd), .memRegWrite(memRegWrite),
    .wbRd(wbRd), .wbRegWrite(wbRegWrite), .wbData(wbData),
    .rdData1(rdData1), .rdData2(rdData2), .fwdSelA(fwdSelA), .fwdSelB(fwdSelB),
    .stall(stall), .bubble(bubble)
  );

  typedef struct packed {
    logic [AW-1:0] id1, id2, ex1, ex2, exD;
    logic          exW, exL;
    logic [AW-1:0] memD;
    logic          memW;
    logic [AW-1:0] wbD;
    logic          wbW;
    logic [1:0]    expA, expB;
    logic          expStall;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{5'd0,  5'd0,  5'd3,  5'd4,  5'd0,  1'b0, 1'b0, 5'd3,  1'b1, 5'd0,  1'b0, 2'd2, 2'd0, 1'b0}, // R1
    '{5'd0,  5'd0,  5'd5,  5'd6,  5'd0,  1'b0, 1'b0, 5'd0,  1'b0, 5'd6,  1'b1, 2'd0, 2'd1, 1'b0}, // R2
    '{5'd0,  5'd0,  5'd7,  5'd7,  5'd0,  1'b0, 1'b0, 5'd7,  1'b1, 5'd7,  1'b1, 2'd2, 2'd2, 1'b0}, // R3
    '{5'd0,  5'd0,  5'd0,  5'd0,  5'd0,  1'b1, 1'b1, 5'd0,  1'b1, 5'd0,  1'b1, 2'd0, 2'd0, 1'b0}, // R4
    '{5'd0,  5'd0,  5'd8,  5'd9,  5'd0,  1'b0, 1'b0, 5'd8,  1'b0, 5'd9,  1'b0, 2'd0, 2'd0, 1'b0}, // R5
    '{5'd0,  5'd0,  5'd8,  5'd0,  5'd0,  1'b0, 1'b0, 5'd8,  1'b0, 5'd8,  1'b1, 2'd1, 2'd0, 1'b0}, // R5 + R2
    '{5'd10, 5'd11, 5'd0,  5'd0,  5'd10, 1'b1, 1'b1, 5'd0,  1'b0, 5'd0,  1'b0, 2'd0, 2'd0, 1'b1}, // R6 rs1
    '{5'd12, 5'd13, 5'd0,  5'd0,  5'd13, 1'b1, 1'b1, 5'd0,  1'b0, 5'd0,  1'b0, 2'd0, 2'd0, 1'b1}, // R6 rs2
    '{5'd14, 5'd15, 5'd0,  5'd0,  5'd16, 1'b1, 1'b1, 5'd0,  1'b0, 5'd0,  1'b0, 2'd0, 2'd0, 1'b0}, // R7 independent
    '{5'd14, 5'd15, 5'd0,  5'd0,  5'd14, 1'b1, 1'b0, 5'd0,  1'b0, 5'd0,  1'b0, 2'd0, 2'd0, 1'b0}, // R7 alu producer
    '{5'd17, 5'd0,  5'd18, 5'd19, 5'd17, 1'b1, 1'b1, 5'd18, 1'b1, 5'd19, 1'b1, 2'd2, 2'd1, 1'b1}, // R6 + R1 overlap
    '{5'd20, 5'd0,  5'd0,  5'd0,  5'd20, 1'b0, 1'b1, 5'd0,  1'b0, 5'd0,  1'b0, 2'd0, 2'd0, 1'b0}, // R5 load no write
    '{5'd0,  5'd0,  5'd21, 5'd22, 5'd0,  1'b0, 1'b0, 5'd22, 1'b1, 5'd21, 1'b1, 2'd1, 2'd2, 1'b0}  // R1 + R2 split
  };

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic stepDrive();
    @(posedge clk);
    #1;
  endtask

  task automatic quiet();
    idRs1 = '0; idRs2 = '0; exRs1 = '0; exRs2 = '0; exRd = '0;
    exRegWrite = 1'b0; exIsLoad = 1'b0; memRd = '0; memRegWrite = 1'b0;
    wbRd = '0; wbRegWrite = 1'b0; wbData = '0;
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    quiet();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // reset state, R9
    idRs1 = 5'd5; idRs2 = 5'd31;
    #1;
    check("R9 reset read1", rdData1, '0);
    check("R9 reset read2", rdData2, '0);
    check("R4 reset stall", {31'd0, stall}, '0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      stepDrive();
      idRs1 = VECS[v].id1; idRs2 = VECS[v].id2;
      exRs1 = VECS[v].ex1; exRs2 = VECS[v].ex2; exRd = VECS[v].exD;
      exRegWrite = VECS[v].exW; exIsLoad = VECS[v].exL;
      memRd = VECS[v].memD; memRegWrite = VECS[v].memW;
      wbRd = VECS[v].wbD; wbRegWrite = VECS[v].wbW; wbData = '0;
      #1;
      check($sformatf("R1-group vec%0d selA", v), {30'd0, fwdSelA}, {30'd0, VECS[v].expA});
      check($sformatf("R2-group vec%0d selB", v), {30'd0, fwdSelB}, {30'd0, VECS[v].expB});
      check($sformatf("R6/R7 vec%0d stall", v), {31'd0, stall}, {31'd0, VECS[v].expStall});
      check($sformatf("R6 vec%0d bubble", v), {31'd0, bubble}, {31'd0, VECS[v].expStall});
    end

    // clean register file for directed tests
    stepDrive();
    quiet();
    rst_n = 1'b0;
    stepDrive();
    rst_n = 1'b1;

    // R8: same-cycle write and read
    stepDrive();
    wbRegWrite = 1'b1; wbRd = 5'd5; wbData = 32'hCAFE_0005; idRs1 = 5'd5; idRs2 = 5'd9;
    #1;
    check("R8 bypass read1", rdData1, 32'hCAFE_0005);
    check("R8 other port unaffected", rdData2, '0);

    // R10: value held after the write
    stepDrive();
    wbRegWrite = 1'b0; wbData = 32'h1234_5678;
    #1;
    check("R10 stored read1", rdData1, 32'hCAFE_0005);

    // R9: write to register 0 is dropped
    stepDrive();
    wbRegWrite = 1'b1; wbRd = 5'd0; wbData = 32'hDEAD_BEEF; idRs1 = 5'd0;
    #1;
    check("R9 zero bypass", rdData1, '0);
    stepDrive();
    wbRegWrite = 1'b0;
    #1;
    check("R9 zero stored", rdData1, '0);

    // R8 on second port, then R10 on both ports
    stepDrive();
    wbRegWrite = 1'b1; wbRd = 5'd31; wbData = 32'h0BAD_F00D; idRs2 = 5'd31;
    #1;
    check("R8 bypass read2", rdData2, 32'h0BAD_F00D);
    stepDrive();
    wbRegWrite = 1'b0; idRs1 = 5'd5;
    #1;
    check("R10 stored read2", rdData2, 32'h0BAD_F00D);
    check("R10 earlier write kept", rdData1, 32'hCAFE_0005);

    // R5: disabled write leaves the register untouched
    stepDrive();
    wbRegWrite = 1'b0; wbRd = 5'd5; wbData = 32'h5555_5555;
    stepDrive();
    #1;
    check("R5 disabled write ignored", rdData1, 32'hCAFE_0005);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule